// File: doc/BRIEF.md
# Serial Port Register and Interrupt Core

This block is the register file and interrupt logic of a classic PC-style serial port. A host reaches it over a byte-wide register bus: a 3-bit offset, a write strobe with write data, and a read strobe with read data. Read data is combinational in the cycle of the read strobe. Any side effect of a read or write takes hold at the clock edge that ends that cycle. At most one of the two strobes is high in any cycle.

The core holds the interrupt-enable, line-control, scratch, divisor and FIFO-control registers. It also holds two sticky flags: receive overrun, and a pending "transmitter empty" event. The transmitter is treated as always ready, so every data write raises the transmit-empty event. The core reads the neighbouring receive FIFO through its count and head byte. It requests pops, loopback pushes and flushes from that FIFO with single-cycle strobes. For the modem-control and modem-status offsets it forwards the accesses to a separate modem block, and takes from that block a 4-bit vector of pending change flags.

From these inputs the core picks one interrupt reason, using a fixed four-level priority. It drives a level interrupt that is high whenever some reason is pending.

Top module: `serial_irq_core`

## Requirements
- R1: While LCR bit 7 (divisor access) is set, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte, in place of the data and interrupt-enable registers.
- R2: After reset the divisor is 12 (low byte 12, high byte 0). Interrupt-enable, line-control, scratch and FIFO-control registers are 0, and the irq output is low.
- R3: A write to offset 1 (divisor access clear) stores only data bits 3:0 into the interrupt-enable register. Bits 7:4 read back as 0. Enable bit positions: 0 receive data, 1 transmit empty, 2 line status, 3 modem status.
- R4: A read of offset 2 returns the highest-priority reason in bits 3:0. The reasons, from highest to lowest, are: overrun with enable bit 2, code 0x6; FIFO count nonzero with enable bit 0, code 0xC; transmit-empty pending with enable bit 1, code 0x2; nonzero modem change vector with enable bit 3, code 0x0. With no reason pending the code is 0x1.
- R5: Each write to the data register (offset 0, divisor access clear) sets the transmit-empty pending flag. An offset 2 read that reports code 0x2 clears the flag; an offset 2 read that reports any other code leaves it set.
- R6: Bits 7:6 of an offset 2 read are 11 when FIFO-control bit 0 is set, and 00 otherwise.
- R7: A read of offset 5 returns bit 6 and bit 5 set, bit 1 equal to the overrun flag, bit 0 set when the FIFO count is nonzero, and every other bit 0. The read clears the overrun flag after the flag has been returned.
- R8: With the loopback input high, a data write strobes rxq_push with the byte when rxq_full is low. When rxq_full is high it instead sets the overrun flag and does not push.
- R9: A write to offset 2 with bit 0 clear sets the FIFO-control register to 0. With bit 0 set it stores the data masked with 0xC9. rxq_flush pulses when bit 0 changes value, or when bit 0 and bit 1 are both set.
- R10: A data read (offset 0, divisor access clear) returns rxq_data and pulses rxq_pop when the FIFO count is nonzero. It returns 0x00 with no pop when the count is zero.
- R11: irq is high exactly when the offset 2 reason code would be other than 0x1. It follows register updates at the next clock edge and follows FIFO count or modem change vector changes at once.
- R12: Writes to offsets 5 and 6 change no state. A write to offset 4 pulses mdm_wr, and a read of offset 6 pulses mdm_rd. Reads of offsets 4 and 6 return mdm_rdata.
- R13: Offsets 3 and 7 read back the last byte written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| loopback | input | 1 | Loopback mode from the modem control block |
| rxq_count | input | CNT_W | Bytes held in the receive FIFO |
| rxq_data | input | 8 | Head byte of the receive FIFO |
| rxq_full | input | 1 | Receive FIFO refuses a push |
| rxq_pop | output | 1 | Remove the head byte |
| rxq_push | output | 1 | Push rxq_push_data into the FIFO |
| rxq_push_data | output | 8 | Byte pushed in loopback |
| rxq_flush | output | 1 | Empty the receive FIFO |
| fifo_cfg | output | 8 | Stored FIFO-control register |
| mdm_delta | input | 4 | Modem status change flags |
| mdm_rdata | input | 8 | Read data of the modem block |
| mdm_wr | output | 1 | Modem control write strobe |
| mdm_rd | output | 1 | Modem status read strobe |
| irq | output | 1 | Interrupt request, level |

## Verification
The priority encoder is tried with several conditions pending at the same time. Overrun is raised together with held data and a pending transmit event, and the bench then removes the conditions one by one. The codes that result show whether the order is right and whether each clearing read affects only its own condition. Loopback writes are tried into a one-deep FIFO and a sixteen-deep FIFO, to tell a normal push from a refused one. The FIFO-control register is written with enable changes, with the receive-reset bit set, and with enable held low. These patterns separate flushes caused by a mode change from flushes caused by the reset bit. Accesses are repeated with divisor access set and clear, to show that only offsets 0 and 1 are redirected.

// File: rtl/serial_irq_pkg.sv
// Shared encodings for the serial port register and interrupt core.
// Assumes a 3-bit register offset and byte-wide data.
package serial_irq_pkg;

    // Interrupt reason codes reported in bits 3:0 of the identification read
    typedef enum logic [3:0] {
        RSN_MODEM   = 4'h0,
        RSN_NONE    = 4'h1,
        RSN_TXEMPTY = 4'h2,
        RSN_LINE    = 4'h6,
        RSN_RXDATA  = 4'hC
    } irq_rsn_e;

    // Register offsets
    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_IEN   = 3'd1;
    localparam logic [2:0] OFS_IDENT = 3'd2;
    localparam logic [2:0] OFS_LCTL  = 3'd3;
    localparam logic [2:0] OFS_MCTL  = 3'd4;
    localparam logic [2:0] OFS_LSTAT = 3'd5;
    localparam logic [2:0] OFS_MSTAT = 3'd6;
    localparam logic [2:0] OFS_SCR   = 3'd7;

    // Interrupt-enable bit positions
    localparam int IEN_RX   = 0;
    localparam int IEN_TX   = 1;
    localparam int IEN_LINE = 2;
    localparam int IEN_MDM  = 3;

    // Bits of the FIFO-control register that are stored
    localparam logic [7:0] FCFG_KEEP = 8'hC9;

endpackage

// File: rtl/serial_irq_regs.sv
// Software-visible configuration registers: interrupt enable, line control,
// scratch, divisor and FIFO control. Also raises the FIFO flush request.
// Assumes that the caller already removed divisor-access redirects from wr_en
// for offsets 0 and 1 (those arrive on dl_lo_wr / dl_hi_wr).
module serial_irq_regs
    import serial_irq_pkg::*;
#(
    parameter logic [15:0] DIV_INIT = 16'd12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    input  logic       dl_lo_wr,
    input  logic       dl_hi_wr,
    output logic [3:0] ier_q,
    output logic [7:0] lcr_q,
    output logic [7:0] scr_q,
    output logic [7:0] dll_q,
    output logic [7:0] dlh_q,
    output logic [7:0] fcr_q,
    output logic       flush
);

    logic       fcr_wr;
    logic [7:0] fcr_d;

    // Decode the FIFO-control write and its flush condition
    always_comb begin
        fcr_wr = wr_en && (addr == OFS_IDENT);
        fcr_d  = wdata[0] ? (wdata & FCFG_KEEP) : 8'h00;
        flush  = fcr_wr && ((fcr_q[0] != wdata[0]) || (wdata[0] && wdata[1]));
    end

    // Register storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier_q <= '0;
            lcr_q <= '0;
            scr_q <= '0;
            fcr_q <= '0;
            dll_q <= DIV_INIT[7:0];
            dlh_q <= DIV_INIT[15:8];
        end else begin
            if (dl_lo_wr) dll_q <= wdata;
            if (dl_hi_wr) dlh_q <= wdata;
            if (wr_en && addr == OFS_IEN)  ier_q <= wdata[3:0];
            if (wr_en && addr == OFS_LCTL) lcr_q <= wdata;
            if (wr_en && addr == OFS_SCR)  scr_q <= wdata;
            if (fcr_wr)                    fcr_q <= fcr_d;
        end
    end

endmodule

// File: rtl/serial_irq_flags.sv
// Sticky event flags: receive overrun and pending transmitter-empty.
// A set and a clear in the same cycle resolve to set, so no event is lost.
module serial_irq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_oe,
    input  logic clr_oe,
    input  logic set_thre,
    input  logic clr_thre,
    output logic oe_q,
    output logic thre_q
);

    // Hold each flag until its clearing access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q   <= 1'b0;
            thre_q <= 1'b0;
        end else begin
            oe_q   <= set_oe   | (oe_q   & ~clr_oe);
            thre_q <= set_thre | (thre_q & ~clr_thre);
        end
    end

endmodule

// File: rtl/serial_irq_prio.sv
// Fixed-priority interrupt reason selector. Purely combinational; assumes
// every condition input is already a level.
module serial_irq_prio
    import serial_irq_pkg::*;
(
    input  logic [3:0] ier,
    input  logic       oe,
    input  logic       rx_any,
    input  logic       thre,
    input  logic       mdm_any,
    output irq_rsn_e   rsn
);

    // Pick the highest enabled condition
    always_comb begin
        if (oe && ier[IEN_LINE])         rsn = RSN_LINE;
        else if (rx_any && ier[IEN_RX])  rsn = RSN_RXDATA;
        else if (thre && ier[IEN_TX])    rsn = RSN_TXEMPTY;
        else if (mdm_any && ier[IEN_MDM]) rsn = RSN_MODEM;
        else                             rsn = RSN_NONE;
    end

endmodule

// File: rtl/serial_irq_core.sv
// Register access and interrupt identification core of a PC-style serial
// port. Decodes the byte bus, muxes read data, raises FIFO and modem strobes
// and drives a level interrupt. Assumes bus_rd and bus_wr are never high in
// the same cycle; read data is combinational with bus_rd.
module serial_irq_core
    import serial_irq_pkg::*;
#(
    parameter int REF_HZ     = 1843200,
    parameter int BAUD       = 9600,
    parameter int OVERSAMPLE = 16,
    parameter int CNT_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [7:0]       bus_wdata,
    input  logic             bus_rd,
    output logic [7:0]       bus_rdata,
    input  logic             loopback,
    input  logic [CNT_W-1:0] rxq_count,
    input  logic [7:0]       rxq_data,
    input  logic             rxq_full,
    output logic             rxq_pop,
    output logic             rxq_push,
    output logic [7:0]       rxq_push_data,
    output logic             rxq_flush,
    output logic [7:0]       fifo_cfg,
    input  logic [3:0]       mdm_delta,
    input  logic [7:0]       mdm_rdata,
    output logic             mdm_wr,
    output logic             mdm_rd,
    output logic             irq
);

    localparam int          DIV_VAL  = REF_HZ / BAUD / OVERSAMPLE;
    localparam logic [15:0] DIV_INIT = DIV_VAL[15:0];

    logic       dlab, dl_sel, rx_any;
    logic       data_wr, data_rd, reg_wr;
    logic [3:0] ier_q;
    logic [7:0] lcr_q, scr_q, dll_q, dlh_q, fcr_q;
    logic       oe_q, thre_q;
    logic       set_oe, clr_oe, clr_thre;
    irq_rsn_e   rsn;

    // Access decode and strobes toward the neighbours
    always_comb begin
        dlab          = lcr_q[7];
        dl_sel        = dlab && (bus_addr == OFS_DATA || bus_addr == OFS_IEN);
        rx_any        = |rxq_count;
        reg_wr        = bus_wr && !dl_sel;
        data_wr       = reg_wr && (bus_addr == OFS_DATA);
        data_rd       = bus_rd && !dl_sel && (bus_addr == OFS_DATA);
        rxq_push      = data_wr && loopback && !rxq_full;
        rxq_push_data = bus_wdata;
        set_oe        = data_wr && loopback && rxq_full;
        rxq_pop       = data_rd && rx_any;
        clr_oe        = bus_rd && (bus_addr == OFS_LSTAT);
        clr_thre      = bus_rd && (bus_addr == OFS_IDENT) && (rsn == RSN_TXEMPTY);
        mdm_wr        = bus_wr && (bus_addr == OFS_MCTL);
        mdm_rd        = bus_rd && (bus_addr == OFS_MSTAT);
        fifo_cfg      = fcr_q;
        irq           = (rsn != RSN_NONE);
    end

    serial_irq_regs #(.DIV_INIT(DIV_INIT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .dl_lo_wr (bus_wr && dlab && bus_addr == OFS_DATA),
        .dl_hi_wr (bus_wr && dlab && bus_addr == OFS_IEN),
        .ier_q    (ier_q),
        .lcr_q    (lcr_q),
        .scr_q    (scr_q),
        .dll_q    (dll_q),
        .dlh_q    (dlh_q),
        .fcr_q    (fcr_q),
        .flush    (rxq_flush)
    );

    serial_irq_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_oe   (set_oe),
        .clr_oe   (clr_oe),
        .set_thre (data_wr),
        .clr_thre (clr_thre),
        .oe_q     (oe_q),
        .thre_q   (thre_q)
    );

    serial_irq_prio u_prio (
        .ier     (ier_q),
        .oe      (oe_q),
        .rx_any  (rx_any),
        .thre    (thre_q),
        .mdm_any (|mdm_delta),
        .rsn     (rsn)
    );

    // Read data multiplexer
    always_comb begin
        unique case (bus_addr)
            OFS_DATA:  bus_rdata = dlab ? dll_q : (rx_any ? rxq_data : 8'h00);
            OFS_IEN:   bus_rdata = dlab ? dlh_q : {4'h0, ier_q};
            OFS_IDENT: bus_rdata = {{2{fcr_q[0]}}, 2'b00, rsn};
            OFS_LCTL:  bus_rdata = lcr_q;
            OFS_MCTL:  bus_rdata = mdm_rdata;
            OFS_LSTAT: bus_rdata = {1'b0, 2'b11, 3'b000, oe_q, rx_any};
            OFS_MSTAT: bus_rdata = mdm_rdata;
            default:   bus_rdata = scr_q;
        endcase
    end

endmodule

// File: rtl/serial_irq_core_chk.sv
// Property checker for serial_irq_core, attached with bind.
// Observes ports and a few state registers of the core.
module serial_irq_core_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic [7:0]       bus_rdata,
    input logic             irq,
    input logic             rxq_pop,
    input logic             rxq_push,
    input logic             rxq_full,
    input logic [CNT_W-1:0] rxq_count,
    input logic [7:0]       lcr_q,
    input logic [3:0]       ier_q,
    input logic             oe_q,
    input logic             thre_q
);

    // R3
    ier_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd1 && !lcr_q[7]) |-> (bus_rdata[7:4] == 4'h0));

    // R7
    lstat_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd5) |-> (bus_rdata[6:5] == 2'b11));

    // R7
    overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd5 && !bus_wr) |=> !oe_q);

    // R5
    thre_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && !lcr_q[7]) |=> thre_q);

    // R10
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_pop |-> (rxq_count != '0));

    // R8
    push_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_push |-> !rxq_full);

    // R11
    quiet_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q == 4'h0) |-> !irq);

endmodule

bind serial_irq_core serial_irq_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .rxq_pop   (rxq_pop),
    .rxq_push  (rxq_push),
    .rxq_full  (rxq_full),
    .rxq_count (rxq_count),
    .lcr_q     (lcr_q),
    .ier_q     (ier_q),
    .oe_q      (oe_q),
    .thre_q    (thre_q)
);

// File: tb/serial_irq_core_test.sv
// Bench for serial_irq_core: behavioural register model plus a queue that
// stands in for the receive FIFO; every bus cycle is compared.
module serial_irq_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 5;
    localparam int DEEP       = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       bus_addr = '0;
    logic             bus_wr = 1'b0;
    logic [7:0]       bus_wdata = '0;
    logic             bus_rd = 1'b0;
    logic [7:0]       bus_rdata;
    logic             loopback = 1'b0;
    logic [CNT_W-1:0] rxq_count = '0;
    logic [7:0]       rxq_data = '0;
    logic             rxq_full = 1'b0;
    logic             rxq_pop, rxq_push, rxq_flush, mdm_wr, mdm_rd, irq;
    logic [7:0]       rxq_push_data, fifo_cfg;
    logic [3:0]       mdm_delta = '0;
    logic [7:0]       mdm_rdata = 8'h5C;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [7:0] m_ier, m_lcr, m_scr, m_dll, m_dlh, m_fcr;
    logic       m_oe, m_thre;
    logic [7:0] q[$];

    serial_irq_core #(.CNT_W(CNT_W)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog got timeout exp completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(string tag, string what, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    function automatic int cap();
        return m_fcr[0] ? DEEP : 1;
    endfunction

    function automatic logic [3:0] exp_rsn();
        if (m_oe && m_ier[2]) return 4'h6;
        if (q.size() > 0 && m_ier[0]) return 4'hC;
        if (m_thre && m_ier[1]) return 4'h2;
        if (mdm_delta != 0 && m_ier[3]) return 4'h0;
        return 4'h1;
    endfunction

    task automatic drive_fifo();
        rxq_count = CNT_W'(q.size());
        rxq_data  = (q.size() > 0) ? q[0] : 8'h00;
        rxq_full  = (q.size() >= cap());
    endtask

    // One bus cycle: drive, check combinational outputs, step model, check irq
    task automatic xfer(bit wr, bit rd, logic [2:0] a, logic [7:0] d, string tag);
        logic       dl;
        logic [3:0] r;
        logic [7:0] e_rd;
        bit         e_push, e_pop, e_flush;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #1;
        dl = m_lcr[7];
        r  = exp_rsn();
        case (a)
            3'd0: e_rd = dl ? m_dll : ((q.size() > 0) ? q[0] : 8'h00);
            3'd1: e_rd = dl ? m_dlh : m_ier;
            3'd2: e_rd = {m_fcr[0] ? 4'hC : 4'h0, r};
            3'd3: e_rd = m_lcr;
            3'd5: e_rd = 8'h60 | {6'd0, m_oe, q.size() > 0};
            3'd7: e_rd = m_scr;
            default: e_rd = mdm_rdata;
        endcase
        e_push  = wr && !dl && a == 0 && loopback && q.size() < cap();
        e_pop   = rd && !dl && a == 0 && q.size() > 0;
        e_flush = wr && a == 2 && ((m_fcr[0] != d[0]) || (d[0] && d[1]));
        if (rd) check(tag, "rdata", bus_rdata, e_rd);
        check(tag, "push", {7'd0, rxq_push}, {7'd0, e_push});
        if (e_push) check(tag, "push_data", rxq_push_data, d);
        check(tag, "pop", {7'd0, rxq_pop}, {7'd0, e_pop});
        check(tag, "flush", {7'd0, rxq_flush}, {7'd0, e_flush});
        check(tag, "mdm_wr", {7'd0, mdm_wr}, {7'd0, wr && a == 4});
        check(tag, "mdm_rd", {7'd0, mdm_rd}, {7'd0, rd && a == 6});
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
        if (wr) begin
            if (dl && a == 0) m_dll = d;
            else if (dl && a == 1) m_dlh = d;
            else case (a)
                3'd0: begin
                    if (loopback) begin
                        if (q.size() < cap()) q.push_back(d); else m_oe = 1'b1;
                    end
                    m_thre = 1'b1;
                end
                3'd1: m_ier = {4'h0, d[3:0]};
                3'd2: begin
                    if (m_fcr[0] != d[0]) q.delete();
                    if (!d[0]) m_fcr = 8'h00;
                    else begin
                        if (d[1]) q.delete();
                        m_fcr = d & 8'hC9;
                    end
                end
                3'd3: m_lcr = d;
                3'd7: m_scr = d;
                default: ;
            endcase
        end
        if (rd) begin
            if (e_pop) void'(q.pop_front());
            if (a == 2 && r == 4'h2) m_thre = 1'b0;
            if (a == 5) m_oe = 1'b0;
        end
        drive_fifo();
        #1;
        check(tag, "irq", {7'd0, irq}, {7'd0, exp_rsn() != 4'h1});
        check(tag, "fifo_cfg", fifo_cfg, m_fcr);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d, string tag);
        xfer(1'b1, 1'b0, a, d, tag);
    endtask

    task automatic rd(logic [2:0] a, string tag);
        xfer(1'b0, 1'b1, a, 8'h00, tag);
    endtask

    initial begin
        m_ier = 0; m_lcr = 0; m_scr = 0; m_fcr = 0; m_dll = 8'd12; m_dlh = 0;
        m_oe = 0; m_thre = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R2 reset state, R1 divisor redirect
        xfer(1'b0, 1'b0, 3'd0, 8'h00, "R2");
        rd(3'd1, "R2"); rd(3'd3, "R2"); rd(3'd7, "R2"); rd(3'd2, "R2");
        wr(3'd3, 8'h80, "R1");
        rd(3'd0, "R1"); rd(3'd1, "R1");
        wr(3'd0, 8'h34, "R1"); wr(3'd1, 8'h12, "R1");
        rd(3'd0, "R1"); rd(3'd1, "R1"); rd(3'd2, "R1");
        wr(3'd3, 8'h03, "R13"); rd(3'd3, "R13");
        rd(3'd0, "R10"); rd(3'd1, "R3");

        // R3 enable mask
        wr(3'd1, 8'hFF, "R3"); rd(3'd1, "R3");

        // R5 transmit-empty event
        wr(3'd0, 8'h41, "R5"); rd(3'd2, "R5"); rd(3'd2, "R5");

        // R8 loopback push into one-deep FIFO, overrun on refusal
        @(negedge clk) loopback = 1'b1;
        wr(3'd0, 8'hA5, "R8"); wr(3'd0, 8'h5A, "R8");
        rd(3'd2, "R4");
        rd(3'd5, "R7"); rd(3'd5, "R7");
        rd(3'd2, "R4"); rd(3'd0, "R10"); rd(3'd2, "R4"); rd(3'd2, "R4");
        rd(3'd0, "R10");
        @(negedge clk) mdm_delta = 4'h2;
        xfer(1'b0, 1'b0, 3'd0, 8'h00, "R11"); rd(3'd2, "R4");
        wr(3'd1, 8'h07, "R11");
        @(negedge clk) mdm_delta = 4'h0;
        wr(3'd1, 8'h0F, "R11");

        // R9 FIFO control, R6 identification bits
        wr(3'd0, 8'h11, "R9");
        wr(3'd2, 8'h01, "R9"); rd(3'd2, "R6");
        for (int i = 0; i < 5; i++) wr(3'd0, 8'h20 + 8'(i), "R8");
        wr(3'd2, 8'hC7, "R9"); rd(3'd5, "R9");
        for (int i = 0; i < 3; i++) wr(3'd0, 8'h70 + 8'(i), "R8");
        for (int i = 0; i < 4; i++) rd(3'd0, "R10");
        wr(3'd2, 8'hFF, "R9"); wr(3'd2, 8'hCF, "R9");
        wr(3'd2, 8'h08, "R9"); wr(3'd2, 8'h0E, "R9"); rd(3'd2, "R6");

        // R12 ignored and forwarded offsets
        wr(3'd0, 8'h01, "R12"); wr(3'd0, 8'h02, "R12");
        wr(3'd5, 8'h00, "R12"); wr(3'd6, 8'hFF, "R12"); rd(3'd5, "R12");
        wr(3'd4, 8'h1F, "R12"); rd(3'd4, "R12"); rd(3'd6, "R12");
        rd(3'd0, "R10");
        wr(3'd7, 8'h9E, "R13"); rd(3'd7, "R13");

        // R11 receive from the line, loopback off
        @(negedge clk) loopback = 1'b0;
        wr(3'd1, 8'h01, "R11"); rd(3'd2, "R11");
        q.push_back(8'hC3); drive_fifo();
        xfer(1'b0, 1'b0, 3'd0, 8'h00, "R11");
        wr(3'd0, 8'h77, "R8"); rd(3'd0, "R10"); rd(3'd0, "R10");
        rd(3'd2, "R4");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule